// File: doc/BRIEF.md
# Staged Subcarrier Frequency Word Loader

This block holds the 32-bit frequency control word that drives a colour subcarrier phase accumulator. Software loads the word as four byte writes on a plain register port (address, data, write strobe). The first three bytes land only in shadow storage. Writing the top byte copies all four shadow bytes into the active word on a single clock edge. The accumulator therefore never runs on a word that is only partly updated.

The accumulator adds the active word on every cycle and wraps modulo 2^32. Its upper bits leave the block as the subcarrier phase.

A one-cycle preset strobe loads either of two stock colour-standard words into both the shadow bytes and the active word at once. After reset the block holds the 525-line standard word.

The register port has no back-pressure: every write is taken in the cycle its strobe is high. The readback port is combinational. The phase output is a free-running sample stream with no handshake.

Top module: `sfw_loader`

## Requirements
- R1: During and right after reset, active_word is 0x21F07C1F, the shadow bytes read back 0x1F, 0x7C, 0xF0, 0x21 at addresses 0x8C..0x8F, and the accumulator starts from 0 (phase 0).
- R2: A write to address 0x8C, 0x8D or 0x8E (byte 0, 1, 2; byte 0 is least significant) updates only that shadow byte and leaves active_word unchanged.
- R3: A write to address 0x8F (byte 3) stores the byte and, on the same clock edge, loads active_word with {written byte, shadow byte 2, shadow byte 1, shadow byte 0}. The new value is visible after that edge.
- R4: A commit always uses the latest value of every shadow byte, including bytes rewritten several times or left over from earlier sequences. A sequence that stops before byte 3 is never partly applied.
- R5: On every clock cycle out of reset, the accumulator adds the active word modulo 2^32. phase_out is the accumulator's top PHASE_W bits (default 10).
- R6: A committed or preset word first affects the accumulator on the edge after the one that loaded it.
- R7: Writes to any address outside 0x8C..0x8F change neither the shadow bytes nor active_word. Readback of such an address returns 0.
- R8: preset_load high with preset_pal=0 loads 0x21F07C1F into the shadow bytes and active_word. With preset_pal=1 it loads 0x2A098ACB (bytes 0xCB, 0x8A, 0x09, 0x2A, lowest first).
- R9: When preset_load and wr_en are high in the same cycle, the preset wins and the write is dropped.
- R10: rd_data combinationally returns the shadow byte selected by rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Readback address |
| rd_data | output | 8 | Shadow byte at rd_addr, 0 if out of range |
| preset_load | input | 1 | Load a stock word into shadow and active storage |
| preset_pal | input | 1 | Preset choice: 0 = 525-line word, 1 = 625-line word |
| active_word | output | 32 | Frequency word driving the accumulator |
| phase_out | output | 10 | Upper accumulator bits (subcarrier phase) |

## Verification
The hardest situation to reach is a commit whose lower shadow bytes mix values from several sources. Some bytes come from an interrupted earlier sequence, some from a preset, and some are rewritten more than once. The result must still be exactly the latest byte of each lane.

Random stimulus writes to random addresses in and around the four-byte window, in any order. It drops in presets and collisions between preset and write, so stale and overwritten shadow bytes build up before each top-byte write. Directed sequences add ordered loads of both standard words, a sequence broken off before the top byte, and out-of-window writes.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NBYTES = WORD_W / BYTE_W;
  localparam logic [WORD_W-1:0] STD525_WORD = 32'h21F07C1F;
  localparam logic [WORD_W-1:0] STD625_WORD = 32'h2A098ACB;
  typedef logic [WORD_W-1:0] freq_word_t;
endpackage

// File: rtl/sfw_addr_decode.sv
module sfw_addr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NBYTES    = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h8C
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NBYTES-1:0] sel
);
  logic [ADDR_W-1:0] offset;
  assign offset = addr - BASE_ADDR;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign sel[i] = en && (offset == ADDR_W'(i));
  end
endmodule

// File: rtl/sfw_shadow_bank.sv
module sfw_shadow_bank #(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned BYTE_W = 8,
  parameter logic [NBYTES*BYTE_W-1:0] RESET_WORD = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NBYTES-1:0]        byte_we,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     preset_load,
  input  logic [NBYTES*BYTE_W-1:0] preset_word,
  input  logic [NBYTES-1:0]        rd_sel,
  output logic [BYTE_W-1:0]        rd_data,
  output logic [NBYTES*BYTE_W-1:0] shadow_word
);
  localparam int unsigned WW = NBYTES * BYTE_W;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        q <= RESET_WORD[i*BYTE_W +: BYTE_W];
      else if (preset_load)
        q <= preset_word[i*BYTE_W +: BYTE_W];
      else if (byte_we[i])
        q <= wr_data;
    end
    assign shadow_word[i*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NBYTES; i++)
      if (rd_sel[i]) rd_data = rd_data | shadow_word[i*BYTE_W +: BYTE_W];
  end

  // R7: no write strobe and no preset means shadow storage holds
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|byte_we) && !preset_load) |=> $stable(shadow_word));

  // R9: preset overrides any lane write
  a_r9_preset_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> (shadow_word == $past(preset_word)));

  logic [WW-1:0] unused_w;
  assign unused_w = shadow_word;
endmodule

// File: rtl/sfw_active_word.sv
module sfw_active_word #(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned BYTE_W = 8,
  parameter logic [NBYTES*BYTE_W-1:0] RESET_WORD = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic [NBYTES*BYTE_W-1:0] shadow_word,
  input  logic                     preset_load,
  input  logic [NBYTES*BYTE_W-1:0] preset_word,
  output logic [NBYTES*BYTE_W-1:0] active_word
);
  localparam int unsigned LOW_W = (NBYTES - 1) * BYTE_W;

  logic [NBYTES*BYTE_W-1:0] commit_word;
  assign commit_word = {wr_data, shadow_word[LOW_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)
      active_word <= RESET_WORD;
    else if (preset_load)
      active_word <= preset_word;
    else if (commit)
      active_word <= commit_word;
  end

  // R2: only a commit or preset may change the active word
  a_r2_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !preset_load) |=> $stable(active_word));

  // R3: commit merges the incoming top byte with the lower shadow lanes
  a_r3_commit_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !preset_load) |=>
      (active_word == {$past(wr_data), $past(shadow_word[LOW_W-1:0])}));

  // R8: preset lands in the active word in one edge
  a_r8_preset_active: assert property (@(posedge clk) disable iff (!rst_n)
    preset_load |=> (active_word == $past(preset_word)));
endmodule

// File: rtl/sfw_phase_acc.sv
module sfw_phase_acc #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_W-1:0]  step,
  output logic [PHASE_W-1:0] phase
);
  logic [WORD_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc + step;
  end

  assign phase = acc[WORD_W-1 -: PHASE_W];

  // R5/R6: each cycle adds the word held at the previous edge
  a_r5_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (acc == $past(acc) + $past(step)));
endmodule

// File: rtl/sfw_loader.sv
module sfw_loader
  import sfw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned PHASE_W   = 10,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h8C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0]  rd_data,
  input  logic               preset_load,
  input  logic               preset_pal,
  output logic [WORD_W-1:0]  active_word,
  output logic [PHASE_W-1:0] phase_out
);
  logic [NBYTES-1:0] wr_sel;
  logic [NBYTES-1:0] rd_sel;
  logic              wr_take;
  logic              commit;
  freq_word_t        preset_word;
  freq_word_t        shadow_word;

  assign wr_take     = wr_en && !preset_load;
  assign commit      = wr_sel[NBYTES-1];
  assign preset_word = preset_pal ? STD625_WORD : STD525_WORD;

  sfw_addr_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BASE_ADDR(BASE_ADDR)) u_wr_dec (
    .en(wr_take), .addr(wr_addr), .sel(wr_sel));

  sfw_addr_decode #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BASE_ADDR(BASE_ADDR)) u_rd_dec (
    .en(1'b1), .addr(rd_addr), .sel(rd_sel));

  sfw_shadow_bank #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .RESET_WORD(STD525_WORD)) u_shadow (
    .clk(clk), .rst_n(rst_n), .byte_we(wr_sel), .wr_data(wr_data),
    .preset_load(preset_load), .preset_word(preset_word),
    .rd_sel(rd_sel), .rd_data(rd_data), .shadow_word(shadow_word));

  sfw_active_word #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .RESET_WORD(STD525_WORD)) u_active (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wr_data(wr_data),
    .shadow_word(shadow_word), .preset_load(preset_load),
    .preset_word(preset_word), .active_word(active_word));

  sfw_phase_acc #(.WORD_W(WORD_W), .PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(active_word), .phase(phase_out));

  // R4: after a commit the active low lanes equal the shadow lanes
  a_r4_latest_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || preset_load) |=> (active_word == shadow_word));
endmodule

// File: tb/sfw_loader_tb.sv
`timescale 1ns/1ps
module sfw_loader_tb_top;
  localparam logic [31:0] W525 = 32'h21F07C1F;
  localparam logic [31:0] W625 = 32'h2A098ACB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_addr = 8'h8C;
  logic preset_load = 1'b0;
  logic preset_pal = 1'b0;
  logic [7:0] rd_data;
  logic [31:0] active_word;
  logic [9:0] phase_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] m_act, m_sh, m_acc;

  always #2 clk = ~clk;

  sfw_loader dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .preset_load(preset_load),
    .preset_pal(preset_pal), .active_word(active_word), .phase_out(phase_out));

  // Requirement model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act <= W525; m_sh <= W525; m_acc <= '0;
    end else begin
      logic [31:0] nsh;
      nsh = m_sh;
      m_acc <= m_acc + m_act;
      if (preset_load) begin
        m_act <= preset_pal ? W625 : W525;
        m_sh  <= preset_pal ? W625 : W525;
      end else if (wr_en && wr_addr >= 8'h8C && wr_addr <= 8'h8F) begin
        nsh[(wr_addr - 8'h8C) * 8 +: 8] = wr_data;
        m_sh <= nsh;
        if (wr_addr == 8'h8F) m_act <= nsh;
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a, input logic [31:0] sh);
    if (a >= 8'h8C && a <= 8'h8F) return sh[(a - 8'h8C) * 8 +: 8];
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " active"}, active_word, m_act);
    check({req, " phase R5"}, {22'd0, phase_out}, {22'd0, m_acc[31:22]});
    check({req, " readback R10"}, {24'd0, rd_data}, {24'd0, exp_rd(rd_addr, m_sh)});
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) cyc();
    // R1 during reset
    check("R1 reset active", active_word, W525);
    check("R1 reset phase", {22'd0, phase_out}, 32'd0);
    rst_n = 1'b1;
    for (int a = 8'h8C; a <= 8'h8F; a++) begin
      rd_addr = 8'(a); #0.1;
      check("R1 reset shadow", {24'd0, rd_data}, {24'd0, W525[(a - 8'h8C) * 8 +: 8]});
    end
    cyc();
    check_all("R1 first cycle");
    check("R5 first add", {22'd0, phase_out}, {22'd0, W525[31:22]});

    // R3: ordered load of 625-line word, explicit literal
    wr(8'h8C, 8'hCB); check("R2 byte0 no commit", active_word, W525);
    wr(8'h8D, 8'h8A); check("R2 byte1 no commit", active_word, W525);
    wr(8'h8E, 8'h09); check("R2 byte2 no commit", active_word, W525);
    check_all("R2");
    wr(8'h8F, 8'h2A); check("R3 commit literal", active_word, W625);
    check_all("R3/R6");

    // R4: interrupted sequence, rewrites, then commit
    wr(8'h8C, 8'h11); wr(8'h8D, 8'h22);
    check("R4 partial not applied", active_word, W625);
    wr(8'h8C, 8'h33); wr(8'h8E, 8'h44);
    wr(8'h8F, 8'h55); check("R4 latest lanes", active_word, 32'h55442233);

    // R7: out-of-window writes
    wr(8'h8B, 8'hFF); wr(8'h90, 8'hFF); wr(8'h0C, 8'hFF);
    check("R7 out of range active", active_word, 32'h55442233);
    rd_addr = 8'h90; #0.1; check("R7 readback zero", {24'd0, rd_data}, 32'd0);
    rd_addr = 8'h8D; #0.1; check("R7 shadow kept", {24'd0, rd_data}, 32'h22);

    // R8 presets
    preset_load = 1'b1; preset_pal = 1'b0; cyc(); preset_load = 1'b0;
    check("R8 preset 525", active_word, W525);
    preset_load = 1'b1; preset_pal = 1'b1; cyc(); preset_load = 1'b0;
    check("R8 preset 625", active_word, W625);
    check_all("R8");

    // R9 collision
    preset_load = 1'b1; preset_pal = 1'b0; wr_en = 1'b1; wr_addr = 8'h8F; wr_data = 8'h77;
    cyc(); preset_load = 1'b0; wr_en = 1'b0;
    check("R9 preset wins", active_word, W525);
    rd_addr = 8'h8F; #0.1; check("R9 byte dropped", {24'd0, rd_data}, 32'h21);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom % 100;
      preset_load = (r < 4);
      preset_pal  = $urandom % 2;
      wr_en       = (r >= 2) && (r < 70);
      wr_addr     = 8'h8A + 8'($urandom % 8);
      wr_data     = 8'($urandom);
      rd_addr     = 8'h8A + 8'($urandom % 8);
      cyc();
      check_all("R2/R3/R4/R7/R9 random");
    end
    preset_load = 1'b0; wr_en = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule